// File: doc/BRIEF.md
# Sign Flag Register and Conditional Branch Resolver

This block holds a three-bit sign record for a small 16-bit processor and resolves conditional branches against it. Each time a flag-producing instruction writes its result back, the block classifies the written value as negative, zero or positive and stores exactly one of three flag bits. Writes from instructions that do not produce flags pass by without effect.

When a conditional branch is presented, the block ANDs the three test bits in the instruction with the stored flags. If any tested flag is set, the branch is taken, and the next PC is the incremented PC plus a sign-extended 9-bit displacement. Otherwise the next PC is the incremented PC. The verdict and the next PC are registered and appear one cycle after the branch is presented. Register file storage and instruction fetch belong to neighbouring blocks.

Top module: `nzp_branch_unit`

## Requirements
- R1: After reset, flags_o reads 3'b010 (zero) and br_valid_o is low.
- R2: A flag-producing writeback of value 0 sets flags_o to 3'b010 on the next clock edge.
- R3: A flag-producing writeback whose bit 15 is 1 sets flags_o to 3'b100 (negative) on the next clock edge.
- R4: A flag-producing writeback that is nonzero with bit 15 clear sets flags_o to 3'b001 (positive) on the next clock edge.
- R5: flags_o always has exactly one bit set.
- R6: Only writebacks whose wb_op_i is 4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b0110, 4'b1010 or 4'b1110 change the flags. Any other opcode, for example 4'b0011 (store) or 4'b1100 (jump), leaves flags_o unchanged.
- R7: An instruction with instr_i[15:12] = 4'b0000 and instr_valid_i high is a branch. One cycle later br_valid_o is high, and br_taken_o is set exactly when instr_i[11:9] (test bits in order negative, zero, positive) ANDed with the flags is nonzero. No other instruction raises br_valid_o.
- R8: For a taken branch, next_pc_o is pc_inc_i plus instr_i[8:0] sign-extended to 16 bits, modulo 2^16.
- R9: For a branch that is not taken, next_pc_o equals pc_inc_i.
- R10: When a writeback and a branch arrive in the same cycle, the branch is tested against the flags held before that writeback.
- R11: A branch with test bits 3'b000 is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_en_i | input | 1 | A result is being written back this cycle |
| wb_op_i | input | 4 | Opcode of the instruction writing back |
| wb_data_i | input | 16 | Value written back |
| instr_valid_i | input | 1 | instr_i holds an instruction to resolve |
| instr_i | input | 16 | Instruction word |
| pc_inc_i | input | 16 | Address following the instruction |
| flags_o | output | 3 | Stored flags: negative, zero, positive |
| br_valid_o | output | 1 | A branch verdict is present |
| br_taken_o | output | 1 | The branch is taken |
| next_pc_o | output | 16 | Resolved next PC |

## Verification
Both results have a latency of one clock edge. The flags reflect a writeback right after the edge that samples it, and a branch verdict with its next PC appears right after the edge that samples the branch. The bench drives inputs at the falling edge. It computes the expected flags and verdicts at the following rising edge using its own model and the flags from before that edge. The flags are read shortly after that rising edge. Verdicts go into a queue that a monitor drains at the next falling edge, and an unexpected or missing verdict counts as a failure.

// File: rtl/nzp_pkg.sv
package nzp_pkg;
  localparam int FLAG_W = 3;

  typedef enum logic [FLAG_W-1:0] {
    CC_POS  = 3'b001,
    CC_ZERO = 3'b010,
    CC_NEG  = 3'b100
  } cc_e;

  localparam logic [3:0] OP_BR  = 4'b0000;
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_LD  = 4'b0010;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_NOT = 4'b1001;
  localparam logic [3:0] OP_LDI = 4'b1010;
  localparam logic [3:0] OP_LEA = 4'b1110;

  function automatic logic op_sets_flags(input logic [3:0] op);
    case (op)
      OP_ADD, OP_AND, OP_NOT, OP_LD, OP_LDR, OP_LDI, OP_LEA: op_sets_flags = 1'b1;
      default: op_sets_flags = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/nzp_classify.sv
module nzp_classify #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]         value_i,
  output logic [nzp_pkg::FLAG_W-1:0] cc_o
);
  import nzp_pkg::*;

  localparam int SIGN_BIT = DATA_W - 1;

  always_comb begin
    if (value_i == '0)          cc_o = CC_ZERO;
    else if (value_i[SIGN_BIT]) cc_o = CC_NEG;
    else                        cc_o = CC_POS;
  end
endmodule

// File: rtl/nzp_flag_reg.sv
module nzp_flag_reg #(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wb_en_i,
  input  logic [3:0]                 wb_op_i,
  input  logic [nzp_pkg::FLAG_W-1:0] cc_i,
  output logic [nzp_pkg::FLAG_W-1:0] flags_o
);
  import nzp_pkg::*;

  logic                upd_en;
  logic [FLAG_W-1:0]   flags_q;
  logic [FLAG_W-1:0]   flags_d;

  always_comb begin
    upd_en  = wb_en_i && op_sets_flags(wb_op_i);
    flags_d = upd_en ? cc_i : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= CC_ZERO;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  assert_flags_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_q) == 1);

  assert_store_jump_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_i && (wb_op_i == 4'b0011 || wb_op_i == 4'b1100)) |=> $stable(flags_q));

  assert_idle_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_en_i |=> $stable(flags_q));
endmodule

// File: rtl/nzp_branch_eval.sv
module nzp_branch_eval #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid_i,
  input  logic [DATA_W-1:0]          instr_i,
  input  logic [DATA_W-1:0]          pc_inc_i,
  input  logic [nzp_pkg::FLAG_W-1:0] flags_i,
  output logic                       br_valid_o,
  output logic                       br_taken_o,
  output logic [DATA_W-1:0]          next_pc_o
);
  import nzp_pkg::*;

  localparam int MASK_LO = OFF_W;
  localparam int MASK_HI = OFF_W + FLAG_W - 1;
  localparam int OP_LO   = DATA_W - 4;
  localparam int EXT_W   = DATA_W - OFF_W;

  logic              is_branch;
  logic [FLAG_W-1:0] mask;
  logic [DATA_W-1:0] disp;
  logic              hit;
  logic [DATA_W-1:0] pc_sel;

  logic              valid_q, valid_d;
  logic              taken_q, taken_d;
  logic [DATA_W-1:0] pc_q, pc_d;
  logic              pc_en;

  always_comb begin
    is_branch = instr_valid_i && (instr_i[DATA_W-1:OP_LO] == OP_BR);
    mask      = instr_i[MASK_HI:MASK_LO];
    disp      = {{EXT_W{instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0]};
    hit       = |(mask & flags_i);
    pc_sel    = hit ? (pc_inc_i + disp) : pc_inc_i;
  end

  always_comb begin
    valid_d = is_branch;
    pc_en   = is_branch;
    taken_d = is_branch ? hit : 1'b0;
    pc_d    = pc_en ? pc_sel : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      pc_q    <= '0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
      pc_q    <= pc_d;
    end
  end

  assign br_valid_o = valid_q;
  assign br_taken_o = taken_q;
  assign next_pc_o  = pc_q;

  assert_taken_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_o |-> br_valid_o);

  assert_verdict_matches_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |=> (br_taken_o == |($past(mask) & $past(flags_i))));

  assert_empty_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && mask == '0) |=> !br_taken_o);

  assert_fallthrough_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !hit) |=> (next_pc_o == $past(pc_inc_i)));
endmodule

// File: rtl/nzp_branch_unit.sv
module nzp_branch_unit #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_en_i,
  input  logic [3:0]        wb_op_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              instr_valid_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] pc_inc_i,
  output logic [2:0]        flags_o,
  output logic              br_valid_o,
  output logic              br_taken_o,
  output logic [DATA_W-1:0] next_pc_o
);
  import nzp_pkg::*;

  logic [FLAG_W-1:0] wb_cc;
  logic [FLAG_W-1:0] flags_cur;

  nzp_classify #(.DATA_W(DATA_W)) u_classify (
    .value_i (wb_data_i),
    .cc_o    (wb_cc)
  );

  nzp_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_en_i (wb_en_i),
    .wb_op_i (wb_op_i),
    .cc_i    (wb_cc),
    .flags_o (flags_cur)
  );

  nzp_branch_eval #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_eval (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .pc_inc_i      (pc_inc_i),
    .flags_i       (flags_cur),
    .br_valid_o    (br_valid_o),
    .br_taken_o    (br_taken_o),
    .next_pc_o     (next_pc_o)
  );

  assign flags_o = flags_cur;

  assert_zero_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_i && op_sets_flags(wb_op_i) && wb_data_i == '0) |=> (flags_o == 3'b010));

  assert_neg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_i && op_sets_flags(wb_op_i) && wb_data_i[DATA_W-1]) |=> (flags_o == 3'b100));
endmodule

// File: tb/tb_nzp_branch_unit.sv
module tb_nzp_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_en_i = 1'b0;
  logic [3:0]  wb_op_i = '0;
  logic [15:0] wb_data_i = '0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] pc_inc_i = '0;
  logic [2:0]  flags_o;
  logic        br_valid_o, br_taken_o;
  logic [15:0] next_pc_o;

  always #4 clk = ~clk;

  nzp_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .wb_en_i(wb_en_i), .wb_op_i(wb_op_i),
    .wb_data_i(wb_data_i), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .pc_inc_i(pc_inc_i), .flags_o(flags_o), .br_valid_o(br_valid_o),
    .br_taken_o(br_taken_o), .next_pc_o(next_pc_o)
  );

  typedef struct { logic taken; logic [15:0] pc; int req; } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  logic [2:0] model_flags;
  bit done = 0;

  function automatic logic [2:0] classify(input logic [15:0] v);
    if (v == 16'h0000) return 3'b010;
    if (v[15])         return 3'b100;
    return 3'b001;
  endfunction

  function automatic bit sets(input logic [3:0] op);
    return op == 4'b0001 || op == 4'b0101 || op == 4'b1001 || op == 4'b0010 ||
           op == 4'b0110 || op == 4'b1010 || op == 4'b1110;
  endfunction

  task automatic check_flags(input int req);
    total++;
    if (flags_o !== model_flags) begin
      bad++;
      $display("FAIL R%0d flags actual=%b expected=%b", req, flags_o, model_flags);
    end
  endtask

  // one cycle: optional writeback and optional instruction together
  task automatic step(input bit we, input logic [3:0] op, input logic [15:0] d,
                      input bit iv, input logic [15:0] ins, input logic [15:0] pci,
                      input int req);
    exp_t e;
    logic [15:0] sx;
    @(negedge clk);
    wb_en_i = we; wb_op_i = op; wb_data_i = d;
    instr_valid_i = iv; instr_i = ins; pc_inc_i = pci;
    @(posedge clk);
    if (iv && ins[15:12] == 4'b0000) begin
      // R10: verdict uses flags from before this edge
      sx = {{7{ins[8]}}, ins[8:0]};
      e.taken = |(ins[11:9] & model_flags);
      e.pc = e.taken ? pci + sx : pci;   // R8 / R9
      e.req = req;
      exp_q.push_back(e);
    end
    if (we && sets(op)) model_flags = classify(d);
    #1;
    check_flags(req);
  endtask

  // monitor: verdicts due one cycle after the branch edge (R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (br_valid_o) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R7 unexpected verdict actual=1 expected=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (br_taken_o !== e.taken || next_pc_o !== e.pc) begin
            bad++;
            $display("FAIL R%0d taken/pc actual=%b/%h expected=%b/%h",
                     e.req, br_taken_o, next_pc_o, e.taken, e.pc);
          end
        end
      end else if (exp_q.size() != 0) begin
        total++; bad++;
        void'(exp_q.pop_front());
        $display("FAIL R7 missing verdict actual=0 expected=1");
      end
    end
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] ops [7];
    model_flags = 3'b010;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    total++;
    if (flags_o !== 3'b010 || br_valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual=%b/%b expected=010/0", flags_o, br_valid_o);
    end
    @(negedge clk); rst_n = 1'b1;

    step(1, 4'b0001, 16'h0000, 0, 0, 0, 2);  // R2 zero
    step(1, 4'b0001, 16'h8000, 0, 0, 0, 3);  // R3 negative
    step(1, 4'b0101, 16'hFFFF, 0, 0, 0, 3);  // R3
    step(1, 4'b0001, 16'h0005, 0, 0, 0, 4);  // R4 positive
    step(1, 4'b0011, 16'h0000, 0, 0, 0, 6);  // R6 store ignored
    step(1, 4'b1100, 16'h8000, 0, 0, 0, 6);  // R6 jump ignored
    step(0, 4'b0001, 16'h0000, 0, 0, 0, 6);  // R6 no enable

    ops = '{4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b0110, 4'b1010, 4'b1110};
    for (int i = 0; i < 7; i++) begin
      step(1, ops[i], 16'h0000, 0, 0, 0, 2);
      step(1, ops[i], 16'h7FFF, 0, 0, 0, 4);
      step(1, ops[i], 16'h8001, 0, 0, 0, 3);
    end
    // flags now negative
    step(1, 4'b0001, 16'h0010, 0, 0, 0, 4);   // positive
    step(0, 0, 0, 1, 16'h0204, 16'h3001, 8);  // R8 mask P, +4 taken
    step(0, 0, 0, 1, 16'h0C04, 16'h3001, 9);  // R9 mask NZ not taken
    step(0, 0, 0, 1, 16'h0000, 16'h3001, 11); // R11 empty mask
    step(0, 0, 0, 1, 16'h0FFF, 16'h3001, 8);  // all bits, offset -1
    step(0, 0, 0, 1, 16'h03FF, 16'h0000, 8);  // wrap down to FFFF
    step(0, 0, 0, 1, 16'h0201, 16'hFFFF, 8);  // wrap up to 0000
    step(0, 0, 0, 1, 16'h0300, 16'h1234, 8);  // most negative offset
    step(0, 0, 0, 1, 16'h1201, 16'h3001, 7);  // R7 non-branch: no verdict
    // R10 same-cycle: flags P, writeback zero, branch on P still taken
    step(1, 4'b0001, 16'h0000, 1, 16'h0210, 16'h4000, 10);
    step(0, 0, 0, 1, 16'h0410, 16'h4000, 7);  // now Z taken
    step(0, 0, 0, 1, 16'h0A10, 16'h4000, 7);  // N|P not taken
    step(1, 4'b1001, 16'h9000, 1, 16'h0810, 16'h5000, 10); // N test, old Z
    step(0, 0, 0, 1, 16'h0810, 16'h5000, 7);  // N taken
    step(0, 0, 0, 0, 0, 0, 7);
    step(0, 0, 0, 0, 0, 0, 7);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule